// File: doc/BRIEF.md
# Programmable Parallel I/O Port Controller

This block is a register-mapped parallel I/O peripheral with three 8-bit ports, named A, B and C. Port C is managed as two separate 4-bit halves. The upper half belongs to group A and the lower half belongs to group B. A host reaches four registers through a synchronous bus: one data register per port, plus a control register. The bus has an active-low chip select, active-low read and write strobes, a 2-bit address, and separate write-data and read-data buses.

A single control word sets the mode and pin direction for both groups. It can be written at any time. The new setting takes effect on the clock edge that accepts the write, and no further initialization is needed. Every write of a control word clears the output latches. Only basic latched input/output behaviour is implemented. The group mode fields for strobed and bidirectional operation are stored and read back, but the ports still behave as basic I/O in those modes.

Each pin group has its own output-enable signal, so the pads outside the block can be built from the pin inputs, the pin outputs and the enables.

Top module: `pio_port_ctrl`

## Requirements
- R1: After reset the control register reads 9Bh, all four output enables are low, and every output latch holds zero.
- R2: A write to address 3 with bit 7 = 1 is stored in the control register and reads back unchanged. The control-word fields are as follows. Bits 6:5 hold the group A mode, bit 2 holds the group B mode, and there are four direction bits where 1 = input and 0 = output. Bit 4 sets the direction of port A, bit 3 sets the upper half of C, bit 1 sets port B and bit 0 sets the lower half of C. Each output enable is high exactly when its direction bit is 0.
- R3: A write to address 3 with bit 7 = 0 leaves the control register and all port outputs unchanged.
- R4: Any accepted control-word write clears every output latch to zero, whatever value the latch held before.
- R5: A write to address 0, 1 or 2 loads the latch of port A, B or C respectively. A port configured as output drives its latch on its pins. Reading that port returns the latch value.
- R6: A read of port A or B configured as input returns the pin values sampled on the clock edge that accepts the read. The returned value stays on the read-data bus until the next accepted read, even if the pins change.
- R7: A read of port C returns each 4-bit half on its own terms. An input half returns its live pin values and an output half returns its latch.
- R8: Mode values other than basic I/O (bits 6:5 = 01, 10 or 11; bit 2 = 1) are stored and read back, and they leave port behaviour identical to basic I/O.
- R9: While chip select is high, write and read strobes have no effect: the registers, the pins and the read-data bus hold their values.
- R10: Bus timing works as follows. A write strobe takes effect on the clock edge where chip select and the write strobe are both low. The read-data bus takes the selected value on the clock edge where chip select and the read strobe are both low and the write strobe is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| csN | input | 1 | Chip select, active low |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| addr | input | 2 | Register select: 0 = A, 1 = B, 2 = C, 3 = control |
| wrData | input | 8 | Host write data |
| rdData | output | 8 | Host read data, registered |
| portAIn | input | 8 | Port A pin inputs |
| portAOut | output | 8 | Port A output latch |
| portAOe | output | 1 | Port A output enable |
| portBIn | input | 8 | Port B pin inputs |
| portBOut | output | 8 | Port B output latch |
| portBOe | output | 1 | Port B output enable |
| portCIn | input | 8 | Port C pin inputs |
| portCOut | output | 8 | Port C output latch |
| portCUpOe | output | 1 | Port C upper half output enable |
| portCLoOe | output | 1 | Port C lower half output enable |

## Verification
The bench goes through all sixteen combinations of the four direction bits, and for each one all eight combinations of the group mode bits. Before every control write it loads non-zero values into all three latches, so a design that failed to clear its outputs would still show the old data. Each case then checks the read-back of the control word, every enable and every read path against values the bench derives from the control-word bits. A design that swapped a direction bit or reversed its polarity would drive the wrong half of C or return latch data instead of pin data. A design that let the mode bits gate behaviour would fail in the non-zero mode settings. Separate cases cover three further faults: a control write with bit 7 clear that corrupts the register, strobes acted on with chip select high, and a read-data bus that follows the pins after the read instead of holding.

// File: rtl/pio_pkg.sv
package pio_pkg;

  localparam int PORT_W = 8;
  localparam int HALF_W = PORT_W / 2;

  localparam logic [1:0] SEL_A    = 2'd0;
  localparam logic [1:0] SEL_B    = 2'd1;
  localparam logic [1:0] SEL_C    = 2'd2;
  localparam logic [1:0] SEL_CTRL = 2'd3;

  // Field positions inside the control word
  localparam int CW_FLAG   = 7;
  localparam int CW_MODEA  = 5;  // two bits, 6:5
  localparam int CW_DIRA   = 4;
  localparam int CW_DIRCU  = 3;
  localparam int CW_MODEB  = 2;
  localparam int CW_DIRB   = 1;
  localparam int CW_DIRCL  = 0;

  localparam logic [PORT_W-1:0] CW_RESET = 8'h9B;

  // Strobes from control to datapath
  typedef struct packed {
    logic       wrA;
    logic       wrB;
    logic       wrC;
    logic       clrOut;
    logic       rdEn;
    logic [1:0] rdSel;
  } strobe_t;

endpackage

// File: rtl/pio_ctrl.sv
module pio_ctrl
  import pio_pkg::*;
#(
  parameter int DW = PORT_W,
  parameter logic [DW-1:0] RESET_WORD = CW_RESET
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          csN,
  input  logic          rdN,
  input  logic          wrN,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] ctrlWord,
  output strobe_t       strb
);

  logic busWrite;
  logic busRead;
  logic ctrlWrite;
  logic modeSet;

  assign busWrite  = !csN && !wrN;
  assign busRead   = !csN && !rdN && wrN;
  assign ctrlWrite = busWrite && (addr == SEL_CTRL);
  assign modeSet   = ctrlWrite && wrData[CW_FLAG];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrlWord <= RESET_WORD;
    end else if (modeSet) begin
      ctrlWord <= wrData;
    end
  end

  always_comb begin
    strb        = '0;
    strb.wrA    = busWrite && (addr == SEL_A);
    strb.wrB    = busWrite && (addr == SEL_B);
    strb.wrC    = busWrite && (addr == SEL_C);
    strb.clrOut = modeSet;
    strb.rdEn   = busRead;
    strb.rdSel  = addr;
  end

  // R3: a control write without the mode-set flag leaves the register alone
  a_r3_flagless_ignored: assert property (@(posedge clk) disable iff (rst)
    (ctrlWrite && !wrData[CW_FLAG]) |=> $stable(ctrlWord));

  // R9: deselected bus never changes the control register
  a_r9_deselect_hold: assert property (@(posedge clk) disable iff (rst)
    csN |=> $stable(ctrlWord));

  // R2: an accepted mode-set word is what the register holds next
  a_r2_word_stored: assert property (@(posedge clk) disable iff (rst)
    modeSet |=> (ctrlWord == $past(wrData)));

  // R10: at most one data strobe per cycle
  a_r10_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.wrA, strb.wrB, strb.wrC, strb.clrOut, strb.rdEn}));

endmodule

// File: rtl/pio_datapath.sv
module pio_datapath
  import pio_pkg::*;
#(
  parameter int DW = PORT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  strobe_t       strb,
  input  logic [DW-1:0] ctrlWord,
  input  logic [DW-1:0] wrData,
  input  logic [DW-1:0] portAIn,
  input  logic [DW-1:0] portBIn,
  input  logic [DW-1:0] portCIn,
  output logic [DW-1:0] portAOut,
  output logic [DW-1:0] portBOut,
  output logic [DW-1:0] portCOut,
  output logic          portAOe,
  output logic          portBOe,
  output logic          portCUpOe,
  output logic          portCLoOe,
  output logic [DW-1:0] rdData
);

  localparam int HW = DW / 2;
  localparam int NP = 3;

  logic [DW-1:0] outLatch [NP];
  logic [NP-1:0] wrSel;
  logic [DW-1:0] cView;
  logic [DW-1:0] rdMux;
  logic          inA, inB, inCU, inCL;

  assign wrSel = {strb.wrC, strb.wrB, strb.wrA};

  // One output latch per port; a mode-set word clears all of them
  for (genvar p = 0; p < NP; p++) begin : g_latch
    always_ff @(posedge clk) begin
      if (rst || strb.clrOut) begin
        outLatch[p] <= '0;
      end else if (wrSel[p]) begin
        outLatch[p] <= wrData;
      end
    end
  end

  // Direction decode: 1 = input. Mode fields are stored but not decoded here.
  assign inA  = ctrlWord[CW_DIRA];
  assign inB  = ctrlWord[CW_DIRB];
  assign inCU = ctrlWord[CW_DIRCU];
  assign inCL = ctrlWord[CW_DIRCL];

  assign portAOut  = outLatch[0];
  assign portBOut  = outLatch[1];
  assign portCOut  = outLatch[2];
  assign portAOe   = !inA;
  assign portBOe   = !inB;
  assign portCUpOe = !inCU;
  assign portCLoOe = !inCL;

  // Port C halves: live pins when input, latch when output
  assign cView[DW-1:HW] = inCU ? portCIn[DW-1:HW] : outLatch[2][DW-1:HW];
  assign cView[HW-1:0]  = inCL ? portCIn[HW-1:0]  : outLatch[2][HW-1:0];

  always_comb begin
    unique case (strb.rdSel)
      SEL_A:   rdMux = inA ? portAIn : outLatch[0];
      SEL_B:   rdMux = inB ? portBIn : outLatch[1];
      SEL_C:   rdMux = cView;
      default: rdMux = ctrlWord;
    endcase
  end

  // The read register doubles as the input latch for A and B
  always_ff @(posedge clk) begin
    if (rst) begin
      rdData <= '0;
    end else if (strb.rdEn) begin
      rdData <= rdMux;
    end
  end

  // R4: after a mode-set word every output latch is zero
  a_r4_clear_a: assert property (@(posedge clk) disable iff (rst)
    strb.clrOut |=> (portAOut == '0));
  a_r4_clear_b: assert property (@(posedge clk) disable iff (rst)
    strb.clrOut |=> (portBOut == '0));
  a_r4_clear_c: assert property (@(posedge clk) disable iff (rst)
    strb.clrOut |=> (portCOut == '0));

  // R5: a data write lands in the selected port's latch
  a_r5_load_a: assert property (@(posedge clk) disable iff (rst)
    strb.wrA |=> (portAOut == $past(wrData)));

  // R6: without an accepted read the read bus holds
  a_r6_read_hold: assert property (@(posedge clk) disable iff (rst)
    !strb.rdEn |=> $stable(rdData));

  // R6: a read of input port A returns the pins seen at that edge
  a_r6_sample_a: assert property (@(posedge clk) disable iff (rst)
    (strb.rdEn && strb.rdSel == SEL_A && inA) |=> (rdData == $past(portAIn)));

endmodule

// File: rtl/pio_port_ctrl.sv
module pio_port_ctrl
  import pio_pkg::*;
#(
  parameter int DW = PORT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          csN,
  input  logic          rdN,
  input  logic          wrN,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData,
  input  logic [DW-1:0] portAIn,
  output logic [DW-1:0] portAOut,
  output logic          portAOe,
  input  logic [DW-1:0] portBIn,
  output logic [DW-1:0] portBOut,
  output logic          portBOe,
  input  logic [DW-1:0] portCIn,
  output logic [DW-1:0] portCOut,
  output logic          portCUpOe,
  output logic          portCLoOe
);

  strobe_t       strb;
  logic [DW-1:0] ctrlWord;

  pio_ctrl #(.DW(DW)) i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .csN      (csN),
    .rdN      (rdN),
    .wrN      (wrN),
    .addr     (addr),
    .wrData   (wrData),
    .ctrlWord (ctrlWord),
    .strb     (strb)
  );

  pio_datapath #(.DW(DW)) i_datapath (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .ctrlWord  (ctrlWord),
    .wrData    (wrData),
    .portAIn   (portAIn),
    .portBIn   (portBIn),
    .portCIn   (portCIn),
    .portAOut  (portAOut),
    .portBOut  (portBOut),
    .portCOut  (portCOut),
    .portAOe   (portAOe),
    .portBOe   (portBOe),
    .portCUpOe (portCUpOe),
    .portCLoOe (portCLoOe),
    .rdData    (rdData)
  );

  // R1: the first cycle after reset presents the input-only configuration
  a_r1_reset_inputs: assert property (@(posedge clk)
    rst |=> (!portAOe && !portBOe && !portCUpOe && !portCLoOe));

endmodule

// File: tb/test_pio_port_ctrl.sv
module test_pio_port_ctrl;

  logic       clk = 1'b0;
  logic       rst;
  logic       csN, rdN, wrN;
  logic [1:0] addr;
  logic [7:0] wrData, rdData;
  logic [7:0] portAIn, portBIn, portCIn;
  logic [7:0] portAOut, portBOut, portCOut;
  logic       portAOe, portBOe, portCUpOe, portCLoOe;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  pio_port_ctrl i_pio_port_ctrl (
    .clk(clk), .rst(rst), .csN(csN), .rdN(rdN), .wrN(wrN), .addr(addr),
    .wrData(wrData), .rdData(rdData),
    .portAIn(portAIn), .portAOut(portAOut), .portAOe(portAOe),
    .portBIn(portBIn), .portBOut(portBOut), .portBOe(portBOe),
    .portCIn(portCIn), .portCOut(portCOut),
    .portCUpOe(portCUpOe), .portCLoOe(portCLoOe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d, input logic sel = 1'b0);
    @(negedge clk);
    csN = sel; wrN = 1'b0; rdN = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    csN = 1'b1; wrN = 1'b1;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    csN = 1'b0; rdN = 1'b0; wrN = 1'b1; addr = a;
    @(negedge clk);
    d = rdData;
    csN = 1'b1; rdN = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [7:0] r, cw, pa, pb, pc, wa, wb, wc, expC;
    rst = 1'b1; csN = 1'b1; rdN = 1'b1; wrN = 1'b1; addr = '0; wrData = '0;
    portAIn = 8'h00; portBIn = 8'h00; portCIn = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1 oe", {portAOe, portBOe, portCUpOe, portCLoOe}, 4'b0000);
    chk("R1 latchA", portAOut, 8'h00);
    chk("R1 latchC", portCOut, 8'h00);
    busRead(2'd3, r);
    chk("R1 ctrl", r, 8'h9B);

    // Sweep: 8 mode settings x 16 direction settings (R2, R4, R5, R6, R7, R8)
    for (int m = 0; m < 8; m++) begin
      for (int d = 0; d < 16; d++) begin
        cw = 8'h80 | (8'(m >> 1) << 5) | (8'(m & 1) << 2)
           | (8'((d >> 3) & 1) << 4) | (8'((d >> 2) & 1) << 3)
           | (8'((d >> 1) & 1) << 1) | 8'(d & 1);
        busWrite(2'd0, 8'h5A ^ 8'(d));
        busWrite(2'd1, 8'hA5 ^ 8'(m));
        busWrite(2'd2, 8'h3C);
        busWrite(2'd3, cw);
        // R4: control write cleared every latch
        chk("R4 clearA", portAOut, 8'h00);
        chk("R4 clearB", portBOut, 8'h00);
        chk("R4 clearC", portCOut, 8'h00);
        // R2 / R8: readback and enables follow direction bits only
        busRead(2'd3, r);
        chk("R2 R8 readback", r, cw);
        chk("R2 enables", {portAOe, portBOe, portCUpOe, portCLoOe},
            {!cw[4], !cw[1], !cw[3], !cw[0]});
        wa = 8'(d * 17 + m * 3 + 1);
        wb = 8'(~wa);
        wc = 8'(wa + 8'h5C);
        pa = 8'(wa ^ 8'hF0);
        pb = 8'(wb ^ 8'h0F);
        pc = 8'(wc ^ 8'hFF);
        portAIn = pa; portBIn = pb; portCIn = pc;
        busWrite(2'd0, wa);
        busWrite(2'd1, wb);
        busWrite(2'd2, wc);
        // R5: latches reach the pins
        chk("R5 outA", portAOut, wa);
        chk("R5 outB", portBOut, wb);
        chk("R5 outC", portCOut, wc);
        // R5 / R6: read path per direction
        busRead(2'd0, r);
        chk("R5 R6 readA", r, cw[4] ? pa : wa);
        busRead(2'd1, r);
        chk("R5 R6 readB", r, cw[1] ? pb : wb);
        // R7: port C halves independent
        expC = {cw[3] ? pc[7:4] : wc[7:4], cw[0] ? pc[3:0] : wc[3:0]};
        busRead(2'd2, r);
        chk("R7 readC", r, expC);
      end
    end

    // R6: input read is held after pins move
    busWrite(2'd3, 8'h9B);
    portAIn = 8'hC3;
    busRead(2'd0, r);
    chk("R6 sample", r, 8'hC3);
    portAIn = 8'h11;
    repeat (3) @(negedge clk);
    chk("R6 hold", rdData, 8'hC3);

    // R3: flagless control write ignored
    busWrite(2'd3, 8'h80);
    busWrite(2'd0, 8'h77);
    busWrite(2'd3, 8'h12);
    busRead(2'd3, r);
    chk("R3 ctrl kept", r, 8'h80);
    chk("R3 outA kept", portAOut, 8'h77);
    chk("R3 oeA kept", {7'd0, portAOe}, 8'h01);

    // R9: deselected strobes do nothing
    busWrite(2'd0, 8'h99, 1'b1);
    chk("R9 outA", portAOut, 8'h77);
    busWrite(2'd3, 8'h9B, 1'b1);
    busRead(2'd3, r);
    chk("R9 ctrl", r, 8'h80);
    @(negedge clk);
    csN = 1'b1; rdN = 1'b0; addr = 2'd0;
    @(negedge clk);
    rdN = 1'b1;
    chk("R9 rd hold", rdData, 8'h80);

    // R10: a write lands on the edge that accepts it
    @(negedge clk);
    csN = 1'b0; wrN = 1'b0; addr = 2'd1; wrData = 8'h3E;
    @(negedge clk);
    chk("R10 write edge", portBOut, 8'h3E);
    csN = 1'b1; wrN = 1'b1;

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule